// File: doc/BRIEF.md
# TDM Highway Serial Framer Port

This block drives and receives one 2.048 Mbit/s time-division highway from an 8.192 MHz system clock. Every line bit lasts four clock cycles. A frame carries 32 one-byte timeslots, 256 bits in all, and repeats every 125 µs, which is 1024 clock cycles.

The transmit half keeps one byte per timeslot in a 32-entry register array that the host writes through a simple write port. It sends the slots in ascending order, each byte most significant bit first. It also raises a frame-start marker during the first bit of slot 0.

The receive half does not depend on the transmit counters. It waits for the rising edge of an incoming frame marker and uses it to set its own bit timing. It then reassembles bytes from the serial input and presents each byte together with its slot index and a one-cycle strobe.

Top module: `tdm_hwy_port`

## Requirements
- R1: While rstN is low, txSer is 0, rxByteValid is 0 and txFrameSync is 1, because the transmit counters are held at slot 0, bit 0.
- R2: txFrameSync is high for exactly 4 consecutive cycles, which are the first bit period of slot 0. Its rising edges are exactly 1024 cycles apart.
- R3: txSer holds each bit for 4 cycles. It changes only on the first cycle of a bit period, and bit periods are counted from the rising edge of txFrameSync.
- R4: Count line bits n = 0..255 from the rising edge of txFrameSync, 4 cycles per bit. Bit n carries bit (7 - n mod 8) of array entry n/8, so slot 0 is sent first and each byte goes out most significant bit first.
- R5: When txWrEn is high at a clock edge, txWrByte is stored into entry txWrSlot. Entry k is copied for transmission at the start of the last bit of slot k-1 (for k = 0, slot 31 of the previous frame). A write to entry k made while slot k is being sent therefore appears only in the next frame.
- R6: rxSer is sampled only on cycle 2 of each 4-cycle bit period. Cycle 0 is the cycle in which the rising sync edge is seen. The value of rxSer on cycles 0, 1 and 3 has no effect.
- R7: A rising edge of rxFrameSync (low on one cycle, high on the next) marks cycle 0 of bit 0 of slot 0. If this happens in the middle of a frame, any partial byte is dropped and the slot count restarts at 0.
- R8: rxByteValid goes high for exactly one cycle, on the cycle after the 8th bit of a slot is sampled. In that cycle rxByte holds the byte, with the first received bit in bit 7, and rxSlot holds the slot index.
- R9: After reset, rxByteValid stays low until the first rising edge of rxFrameSync has been seen.
- R10: A one-cycle rxFrameSync pulse is enough to align the receiver. A pulse held high for many cycles aligns it only once, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.192 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txWrEn | input | 1 | Write strobe for the transmit slot array |
| txWrSlot | input | 5 | Slot index written |
| txWrByte | input | 8 | Byte written |
| txSer | output | 1 | Transmit serial data |
| txFrameSync | output | 1 | Transmit frame-start marker |
| rxSer | input | 1 | Receive serial data |
| rxFrameSync | input | 1 | Receive frame-start marker |
| rxByte | output | 8 | Reassembled receive byte |
| rxSlot | output | 5 | Slot index of rxByte |
| rxByteValid | output | 1 | One-cycle strobe marking rxByte and rxSlot |

## Verification
On the transmit side, a slip of the phase or bit counter shows up within one bit period: txSer changes in the middle of a bit, or the marker width moves away from 4 cycles. A wrong slot counter shows up at the next frame start, as a 1024-cycle spacing violation or as bytes arriving in the wrong slots. An off-by-one in the staging point shows up only when the host writes during a slot, so a mid-slot write is checked against both the current frame and the next one. On the receive side, the bench drives the complement of each bit on every cycle except the sampling cycle, so a wrong sampling phase corrupts the very first byte. Realignment errors appear as a wrong rxSlot at the first strobe after a sync edge.

// File: rtl/tdm_hwy_pkg.sv
`timescale 1ns/1ps
package tdm_hwy_pkg;
  // frame geometry
  localparam int SLOTS       = 32;
  localparam int BITS        = 8;
  localparam int CYC_PER_BIT = 4;
  localparam int SAMPLE_PH   = CYC_PER_BIT / 2;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(BITS);
  localparam int PH_W   = $clog2(CYC_PER_BIT);

  // strobes from the control counters to the datapath
  typedef struct packed {
    logic              txStage;      // copy next slot's entry into staging
    logic [SLOT_W-1:0] txStageSlot;  // entry to copy
    logic              txLoad;       // move staging into shifter
    logic              txShift;      // advance shifter one bit
    logic              rxSample;     // take rxSer this cycle
    logic              rxLast;       // this sample completes a byte
    logic [SLOT_W-1:0] rxSlot;       // slot of the byte being built
  } strobe_t;
endpackage

// File: rtl/tdm_hwy_ctrl.sv
`timescale 1ns/1ps
module tdm_hwy_ctrl
  import tdm_hwy_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxFrameSync,
  output strobe_t strb,
  output logic    txFrameSync
);
  // transmit timing
  logic [PH_W-1:0]   txPh;
  logic [BIT_W-1:0]  txBit;
  logic [SLOT_W-1:0] txSlot;
  logic txPhLast, txBitLast, txSlotLast;

  assign txPhLast   = (txPh == PH_W'(CYC_PER_BIT - 1));
  assign txBitLast  = (txBit == BIT_W'(BITS - 1));
  assign txSlotLast = (txSlot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh   <= '0;
      txBit  <= '0;
      txSlot <= '0;
    end else begin
      txPh <= txPhLast ? '0 : txPh + PH_W'(1);
      if (txPhLast) begin
        txBit <= txBitLast ? '0 : txBit + BIT_W'(1);
        if (txBitLast)
          txSlot <= txSlotLast ? '0 : txSlot + SLOT_W'(1);
      end
    end
  end

  assign txFrameSync = (txSlot == '0) && (txBit == '0);

  // receive timing
  logic              rxSyncPrev;
  logic              rxLocked;
  logic [PH_W-1:0]   rxPh;
  logic [BIT_W-1:0]  rxBit;
  logic [SLOT_W-1:0] rxSlotCnt;
  logic rxRise, rxPhLast, rxBitLast, rxSlotLast;

  assign rxRise     = rxFrameSync && !rxSyncPrev;
  assign rxPhLast   = (rxPh == PH_W'(CYC_PER_BIT - 1));
  assign rxBitLast  = (rxBit == BIT_W'(BITS - 1));
  assign rxSlotLast = (rxSlotCnt == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSyncPrev <= 1'b0;
      rxLocked   <= 1'b0;
      rxPh       <= '0;
      rxBit      <= '0;
      rxSlotCnt  <= '0;
    end else begin
      rxSyncPrev <= rxFrameSync;
      if (rxRise) begin
        // the rising cycle is phase 0 of bit 0, slot 0
        rxLocked  <= 1'b1;
        rxPh      <= PH_W'(1);
        rxBit     <= '0;
        rxSlotCnt <= '0;
      end else if (rxLocked) begin
        rxPh <= rxPhLast ? '0 : rxPh + PH_W'(1);
        if (rxPhLast) begin
          rxBit <= rxBitLast ? '0 : rxBit + BIT_W'(1);
          if (rxBitLast)
            rxSlotCnt <= rxSlotLast ? '0 : rxSlotCnt + SLOT_W'(1);
        end
      end
    end
  end

  always_comb begin
    strb.txStage     = (txPh == '0) && txBitLast;
    strb.txStageSlot = txSlotLast ? '0 : txSlot + SLOT_W'(1);
    strb.txLoad      = txPhLast && txBitLast;
    strb.txShift     = txPhLast && !txBitLast;
    strb.rxSample    = rxLocked && !rxRise && (rxPh == PH_W'(SAMPLE_PH));
    strb.rxLast      = strb.rxSample && rxBitLast;
    strb.rxSlot      = rxSlotCnt;
  end
endmodule

// File: rtl/tdm_hwy_dpath.sv
`timescale 1ns/1ps
module tdm_hwy_dpath
  import tdm_hwy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [BITS-1:0]   wrByte,
  input  logic              rxSer,
  output logic              txSer,
  output logic [BITS-1:0]   rxByte,
  output logic [SLOT_W-1:0] rxSlot,
  output logic              rxByteValid
);
  // transmit slot array, one register per entry
  logic [BITS-1:0] slotMem [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotMem[g] <= '0;
      else if (wrEn && (wrSlot == SLOT_W'(g)))
        slotMem[g] <= wrByte;
    end
  end

  logic [BITS-1:0] txStageReg;
  logic [BITS-1:0] txShReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txStageReg <= '0;
      txShReg    <= '0;
    end else begin
      if (strb.txStage)
        txStageReg <= slotMem[strb.txStageSlot];
      if (strb.txLoad)
        txShReg <= txStageReg;
      else if (strb.txShift)
        txShReg <= {txShReg[BITS-2:0], 1'b0};
    end
  end

  assign txSer = txShReg[BITS-1];

  // receive byte assembly
  logic [BITS-1:0] rxShReg;
  logic [BITS-1:0] rxNext;

  assign rxNext = {rxShReg[BITS-2:0], rxSer};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShReg     <= '0;
      rxByte      <= '0;
      rxSlot      <= '0;
      rxByteValid <= 1'b0;
    end else begin
      if (strb.rxSample)
        rxShReg <= rxNext;
      rxByteValid <= strb.rxLast;
      if (strb.rxLast) begin
        rxByte <= rxNext;
        rxSlot <= strb.rxSlot;
      end
    end
  end
endmodule

// File: rtl/tdm_hwy_port.sv
`timescale 1ns/1ps
module tdm_hwy_port
  import tdm_hwy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWrEn,
  input  logic [SLOT_W-1:0] txWrSlot,
  input  logic [BITS-1:0]   txWrByte,
  output logic              txSer,
  output logic              txFrameSync,
  input  logic              rxSer,
  input  logic              rxFrameSync,
  output logic [BITS-1:0]   rxByte,
  output logic [SLOT_W-1:0] rxSlot,
  output logic              rxByteValid
);
  strobe_t strb;

  tdm_hwy_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxFrameSync (rxFrameSync),
    .strb        (strb),
    .txFrameSync (txFrameSync)
  );

  tdm_hwy_dpath uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrEn        (txWrEn),
    .wrSlot      (txWrSlot),
    .wrByte      (txWrByte),
    .rxSer       (rxSer),
    .txSer       (txSer),
    .rxByte      (rxByte),
    .rxSlot      (rxSlot),
    .rxByteValid (rxByteValid)
  );
endmodule

// File: rtl/tdm_hwy_port_chk.sv
`timescale 1ns/1ps
module tdm_hwy_port_chk
  import tdm_hwy_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              txSer,
  input logic              txFrameSync,
  input logic              rxFrameSync,
  input logic              rxByteValid,
  input logic [SLOT_W-1:0] rxSlot
);
  localparam int FRAME_CYC = SLOTS * BITS * CYC_PER_BIT;
  localparam int FC_W      = $clog2(FRAME_CYC) + 1;

  logic            fsPrev, fsSeenRise, rxSeenSync;
  logic [3:0]      fsHighLen;
  logic [FC_W-1:0] frameCnt;
  logic [PH_W-1:0] chkPh;
  logic [SLOT_W-1:0] lastSlot;
  logic fsRise;

  assign fsRise = txFrameSync && !fsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev     <= 1'b1;
      fsSeenRise <= 1'b0;
      rxSeenSync <= 1'b0;
      fsHighLen  <= '0;
      frameCnt   <= '0;
      chkPh      <= '0;
      lastSlot   <= '0;
    end else begin
      fsPrev    <= txFrameSync;
      fsHighLen <= txFrameSync ? fsHighLen + 4'd1 : 4'd0;
      frameCnt  <= fsRise ? FC_W'(1) : frameCnt + FC_W'(1);
      chkPh     <= fsRise ? PH_W'(1) : chkPh + PH_W'(1);
      if (fsRise) fsSeenRise <= 1'b1;
      if (rxFrameSync) rxSeenSync <= 1'b1;
      if (rxByteValid) lastSlot <= rxSlot;
    end
  end

  // R2
  fs_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFrameSync) |-> fsHighLen == 4'(CYC_PER_BIT));

  // R2
  fs_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsRise && fsSeenRise) |-> frameCnt == FC_W'(FRAME_CYC));

  // R3
  ser_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsSeenRise && !fsRise && chkPh != '0) |-> $stable(txSer));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxByteValid |=> !rxByteValid);

  // R8
  slot_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && rxSlot != '0) |-> rxSlot == lastSlot + SLOT_W'(1));

  // R9
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxByteValid |-> rxSeenSync);
endmodule

bind tdm_hwy_port tdm_hwy_port_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .txSer       (txSer),
  .txFrameSync (txFrameSync),
  .rxFrameSync (rxFrameSync),
  .rxByteValid (rxByteValid),
  .rxSlot      (rxSlot)
);

// File: tb/tdm_hwy_port_test.sv
`timescale 1ns/1ps
module tdm_hwy_port_test;
  import tdm_hwy_pkg::*;

  typedef logic [7:0] frame_t [32];

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       txWrEn = 1'b0;
  logic [4:0] txWrSlot = '0;
  logic [7:0] txWrByte = '0;
  logic       txSer, txFrameSync;
  logic       rxSer = 1'b0;
  logic       rxFrameSync = 1'b0;
  logic [7:0] rxByte;
  logic [4:0] rxSlot;
  logic       rxByteValid;

  tdm_hwy_port uut (
    .clk(clk), .rstN(rstN),
    .txWrEn(txWrEn), .txWrSlot(txWrSlot), .txWrByte(txWrByte),
    .txSer(txSer), .txFrameSync(txFrameSync),
    .rxSer(rxSer), .rxFrameSync(rxFrameSync),
    .rxByte(rxByte), .rxSlot(rxSlot), .rxByteValid(rxByteValid)
  );

  int checks = 0;
  int errors = 0;
  int validCount = 0;
  bit prevValid = 1'b0;
  logic [12:0] expQ [$];
  frame_t shadow;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected line bit n of a frame, computed from the requirement
  function automatic logic expBit(input frame_t f, input int n);
    return f[n / 8][7 - (n % 8)];
  endfunction

  task automatic wrSlot(input int s, input logic [7:0] v);
    @(negedge clk);
    txWrEn = 1'b1; txWrSlot = 5'(s); txWrByte = v;
    @(negedge clk);
    txWrEn = 1'b0;
    shadow[s] = v;
  endtask

  task automatic waitFrameStart();
    while (txFrameSync) @(negedge clk);
    while (!txFrameSync) @(negedge clk);
  endtask

  // called on the negedge where txFrameSync has just risen
  task automatic captureTx(input bit doMid, input int midSlot, input logic [7:0] midVal);
    frame_t expF;
    logic [7:0] got [32];
    logic curBit = 1'b0;
    bit fsOk = 1'b1;
    bit stableOk = 1'b1;
    expF = shadow;
    for (int n = 0; n < 1024; n++) begin
      if (n > 0) @(negedge clk);
      txWrEn = 1'b0;
      if (doMid && n == (midSlot * 8 + 3) * 4) begin
        txWrEn = 1'b1; txWrSlot = 5'(midSlot); txWrByte = midVal;
        shadow[midSlot] = midVal;
      end
      if (txFrameSync != (n < 4)) fsOk = 1'b0;
      if (n % 4 == 0) begin
        curBit = txSer;
        got[n / 32] = {got[n / 32][6:0], txSer};
      end else if (txSer != curBit) begin
        stableOk = 1'b0;
      end
    end
    txWrEn = 1'b0;
    chk(fsOk, "R2 marker shape", fsOk, 1);
    chk(stableOk, "R3 bit held 4 cycles", stableOk, 1);
    for (int s = 0; s < 32; s++) begin
      logic [7:0] e;
      for (int b = 0; b < 8; b++) e[7 - b] = expBit(expF, s * 8 + b);
      chk(got[s] == e, $sformatf("R4 slot %0d", s), got[s], e);
    end
  endtask

  task automatic sendRx(input frame_t f, input int nSlots, input int syncW, input int partial);
    for (int s = 0; s < nSlots; s++) begin
      expQ.push_back({5'(s), f[s]});
      for (int b = 0; b < 8; b++) begin
        for (int j = 0; j < 4; j++) begin
          @(negedge clk);
          rxFrameSync = ((s * 32 + b * 4 + j) < syncW);
          // R6: correct value only on sampling cycle 2
          rxSer = (j == 2) ? f[s][7 - b] : ~f[s][7 - b];
        end
      end
    end
    for (int k = 0; k < partial * 4; k++) begin
      @(negedge clk);
      rxFrameSync = 1'b0;
      rxSer = 1'($urandom());
    end
  endtask

  // receive monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rxByteValid) begin
        validCount++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R9 unexpected rxByteValid", 1, 0);
        end else begin
          logic [12:0] e;
          e = expQ.pop_front();
          chk(rxSlot == e[12:8], "R7 rxSlot", rxSlot, e[12:8]);
          chk(rxByte == e[7:0], "R6 rxByte", rxByte, e[7:0]);
        end
        if (prevValid) chk(1'b0, "R8 strobe longer than one cycle", 2, 1);
      end
      prevValid = rxByteValid;
    end
  end

  initial begin
    #(190000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    frame_t rf;
    int errBefore;
    void'($urandom(32'd5123));
    for (int s = 0; s < 32; s++) shadow[s] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(txSer == 1'b0, "R1 txSer in reset", txSer, 0);
    chk(rxByteValid == 1'b0, "R1 rxByteValid in reset", rxByteValid, 0);
    chk(txFrameSync == 1'b1, "R1 txFrameSync in reset", txFrameSync, 1);
    rstN = 1'b1;

    // R9: no strobe while no receive sync has been seen
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      rxSer = 1'($urandom());
    end
    chk(validCount == 0, "R9 no strobe before sync", validCount, 0);

    // R4 directed and random frames
    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < 32; s++) begin
        logic [7:0] v;
        case (p)
          0: v = 8'h00;
          1: v = 8'hFF;
          2: v = (s % 2 == 0) ? 8'h80 : 8'h01;
          default: v = 8'($urandom());
        endcase
        wrSlot(s, v);
      end
      waitFrameStart();
      waitFrameStart();
      captureTx(1'b0, 0, 8'h00);
    end

    // R5: write into the slot being sent; new value appears next frame
    waitFrameStart();
    waitFrameStart();
    captureTx(1'b1, 5, ~shadow[5]);
    @(negedge clk);
    chk(txFrameSync == 1'b1, "R2 frame period 1024 cycles", txFrameSync, 1);
    captureTx(1'b0, 0, 8'h00);
    chk(1'b1, "R5 staging point (per-slot checks above)", 1, 1);

    // receive: full frame, short pulse
    for (int s = 0; s < 32; s++) rf[s] = 8'($urandom());
    sendRx(rf, 32, 1, 0);
    // R7 mid-frame realignment with a dropped partial byte
    for (int s = 0; s < 32; s++) rf[s] = 8'($urandom());
    sendRx(rf, 10, 4, 3);
    // R10 long sync pulse aligns once
    errBefore = errors;
    for (int s = 0; s < 32; s++) rf[s] = 8'($urandom());
    sendRx(rf, 32, 40, 0);
    chk(errors == errBefore, "R10 long sync aligned once", errors - errBefore, 0);
    for (int s = 0; s < 32; s++) rf[s] = (s % 2 == 0) ? 8'hA5 : 8'h3C;
    sendRx(rf, 32, 4, 0);
    @(negedge clk);
    rxFrameSync = 1'b0;
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R8 every byte strobed", expQ.size(), 0);
    chk(validCount == 32 + 10 + 32 + 32, "R8 strobe count", validCount, 106);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule